// File: doc/BRIEF.md
# Array Descriptor Indexer and Access Guard

This block checks and applies references made through an array descriptor. A descriptor carries a 20-bit memory base, a length field, and five flag bits: present, indexed, double-width, read-only and copy. Each strobe carries one request. The request is one of three kinds: an index request against a whole-array descriptor, a read through an element descriptor, or a write through an element descriptor.

An index request checks the element number against the array length. A double-width descriptor has its element number doubled before the check. If the check passes, the scaled index replaces the length field and the indexed flag is set. A read or write through a present element descriptor returns the absolute address, which is the base plus the length field.

Any broken protection rule raises exactly one interrupt flag, chosen by a fixed priority. When a flag is raised, the descriptor comes back unchanged and the address output is zero. All results are registered and appear one cycle after the strobe.

Top module: `desc_index_check`

## Requirements
- R1: During and directly after synchronous reset, `out_valid` and all four interrupt flags are 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1, and 0 otherwise; results leave in request order.
- R3: Any request with present flag 0 raises `irq_absent` only, returns the descriptor unchanged and gives address 0.
- R4: An index request (op 2'b00) on a present, non-indexed descriptor with scaled index < length returns length = scaled index, indexed flag = 1, all other fields unchanged, address 0, no flag.
- R5: When the double-width flag is 1, the scaled index is index×2 computed without losing the carry bit, so index 2^19+1 with any 20-bit length is out of range.
- R6: An index request whose scaled index is ≥ length raises `irq_range` and returns the descriptor unchanged (indexed flag stays 0); scaled index = length−1 is accepted.
- R7: An index request on a descriptor whose indexed flag is 1 raises `irq_badop`.
- R8: A read (op 2'b01) or write (op 2'b10) through a present, indexed descriptor returns address = (base + length) mod 2^20, with the descriptor unchanged.
- R9: A write through a descriptor with read-only flag 1 raises `irq_rdonly` and gives address 0; a read through it is accepted.
- R10: A read or write through a non-indexed descriptor, or any request with op 2'b11, raises `irq_badop`.
- R11: At most one flag is 1 per result, with priority absent > badop > range > rdonly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 00 index, 01 read, 10 write, 11 illegal |
| in_base | input | 20 | Descriptor memory base |
| in_len | input | 20 | Descriptor length / element field |
| in_present | input | 1 | Present flag |
| in_indexed | input | 1 | Indexed flag |
| in_dbl | input | 1 | Double-width flag |
| in_ro | input | 1 | Read-only flag |
| in_copy | input | 1 | Copy flag |
| in_index | input | 20 | Element number for index requests |
| out_valid | output | 1 | Result strobe |
| out_base | output | 20 | Result base |
| out_len | output | 20 | Result length / element field |
| out_present | output | 1 | Result present flag |
| out_indexed | output | 1 | Result indexed flag |
| out_dbl | output | 1 | Result double-width flag |
| out_ro | output | 1 | Result read-only flag |
| out_copy | output | 1 | Result copy flag |
| out_abs | output | 20 | Absolute address (0 unless a read or write is accepted) |
| irq_absent | output | 1 | Presence interrupt |
| irq_badop | output | 1 | Invalid operation interrupt |
| irq_range | output | 1 | Invalid index interrupt |
| irq_rdonly | output | 1 | Read-only write interrupt |

## Verification
Priority resolution is the hardest behaviour to reach. It only shows when several rules are broken at once, for example an absent descriptor that is also indexed and read-only and receives a write. The stimulus builds such descriptors on purpose to check that only the top flag appears. The doubling carry also needs targeted values: an index with bit 19 set, combined with the largest length. Without that case, a scaler that drops the carry would wrap into range and pass.

// File: rtl/desc_pkg.sv
package desc_pkg;
  typedef enum logic [1:0] {
    OP_INDEX = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_ILL   = 2'b11
  } desc_op_e;
endpackage

// File: rtl/desc_index_unit.sv
module desc_index_unit #(
  parameter int LEN_W = 20
) (
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] len,
  input  logic             dbl,
  output logic [LEN_W:0]   scaled,
  output logic             over
);
  // carry bit kept so a doubled index never wraps back into range
  always_comb begin
    scaled = dbl ? {idx, 1'b0} : {1'b0, idx};
    over   = scaled >= {1'b0, len};
  end
endmodule

// File: rtl/desc_access_unit.sv
module desc_access_unit #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] abs_addr
);
  always_comb abs_addr = base + ADDR_W'(len);
endmodule

// File: rtl/desc_fault_prio.sv
module desc_fault_prio (
  input  logic f_absent,
  input  logic f_badop,
  input  logic f_range,
  input  logic f_rdonly,
  output logic g_absent,
  output logic g_badop,
  output logic g_range,
  output logic g_rdonly,
  output logic clean
);
  always_comb begin
    g_absent = f_absent;
    g_badop  = !f_absent && f_badop;
    g_range  = !f_absent && !f_badop && f_range;
    g_rdonly = !f_absent && !f_badop && !f_range && f_rdonly;
    clean    = !(f_absent || f_badop || f_range || f_rdonly);
  end
endmodule

// File: rtl/desc_index_check.sv
module desc_index_check
  import desc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_present,
  input  logic              in_indexed,
  input  logic              in_dbl,
  input  logic              in_ro,
  input  logic              in_copy,
  input  logic [LEN_W-1:0]  in_index,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_base,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_present,
  output logic              out_indexed,
  output logic              out_dbl,
  output logic              out_ro,
  output logic              out_copy,
  output logic [ADDR_W-1:0] out_abs,
  output logic              irq_absent,
  output logic              irq_badop,
  output logic              irq_range,
  output logic              irq_rdonly
);
  logic [LEN_W:0]    scaled;
  logic              over;
  logic [ADDR_W-1:0] sum;
  logic              is_idx, is_rd, is_wr, is_rw;
  logic              f_absent, f_badop, f_range, f_rdonly;
  logic              g_absent, g_badop, g_range, g_rdonly, clean;
  logic [LEN_W-1:0]  nxt_len;
  logic              nxt_indexed;
  logic [ADDR_W-1:0] nxt_abs;

  desc_index_unit #(.LEN_W(LEN_W)) u_idx (
    .idx(in_index), .len(in_len), .dbl(in_dbl), .scaled(scaled), .over(over)
  );

  desc_access_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_acc (
    .base(in_base), .len(in_len), .abs_addr(sum)
  );

  always_comb begin
    is_idx   = in_op == OP_INDEX;
    is_rd    = in_op == OP_READ;
    is_wr    = in_op == OP_WRITE;
    is_rw    = is_rd || is_wr;
    f_absent = !in_present;
    f_badop  = is_idx ? in_indexed : (is_rw ? !in_indexed : 1'b1);
    f_range  = is_idx && over;
    f_rdonly = is_wr && in_ro;
  end

  desc_fault_prio u_prio (
    .f_absent(f_absent), .f_badop(f_badop), .f_range(f_range), .f_rdonly(f_rdonly),
    .g_absent(g_absent), .g_badop(g_badop), .g_range(g_range), .g_rdonly(g_rdonly),
    .clean(clean)
  );

  always_comb begin
    nxt_len     = in_len;
    nxt_indexed = in_indexed;
    nxt_abs     = '0;
    if (clean && is_idx) begin
      nxt_len     = scaled[LEN_W-1:0];
      nxt_indexed = 1'b1;
    end
    if (clean && is_rw) nxt_abs = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_base    <= '0;
      out_len     <= '0;
      out_present <= 1'b0;
      out_indexed <= 1'b0;
      out_dbl     <= 1'b0;
      out_ro      <= 1'b0;
      out_copy    <= 1'b0;
      out_abs     <= '0;
      irq_absent  <= 1'b0;
      irq_badop   <= 1'b0;
      irq_range   <= 1'b0;
      irq_rdonly  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_base    <= in_base;
      out_len     <= nxt_len;
      out_present <= in_present;
      out_indexed <= nxt_indexed;
      out_dbl     <= in_dbl;
      out_ro      <= in_ro;
      out_copy    <= in_copy;
      out_abs     <= nxt_abs;
      irq_absent  <= in_valid && g_absent;
      irq_badop   <= in_valid && g_badop;
      irq_range   <= in_valid && g_range;
      irq_rdonly  <= in_valid && g_rdonly;
    end
  end

  assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_flags_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(irq_absent || irq_badop || irq_range || irq_rdonly));
  assert_single_flag_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_absent, irq_badop, irq_range, irq_rdonly}));
  assert_absent_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_present) |-> (irq_absent && out_abs == '0));
  assert_index_applied_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_INDEX && in_present && !in_indexed) |=> (out_indexed ^ irq_range));
  assert_range_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && irq_range) |-> !out_indexed);
  assert_rdonly_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && irq_rdonly) |-> (out_ro && out_abs == '0));
endmodule

// File: tb/desc_index_check_bench.sv
module desc_index_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int LW = 20;
  localparam int EW = AW + LW + 5 + AW + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [AW-1:0] in_base = '0;
  logic [LW-1:0] in_len = '0, in_index = '0;
  logic in_present = 0, in_indexed = 0, in_dbl = 0, in_ro = 0, in_copy = 0;
  logic out_valid, out_present, out_indexed, out_dbl, out_ro, out_copy;
  logic [AW-1:0] out_base, out_abs;
  logic [LW-1:0] out_len;
  logic irq_absent, irq_badop, irq_range, irq_rdonly;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [EW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_index_check u_desc_index_check (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_base(in_base),
    .in_len(in_len), .in_present(in_present), .in_indexed(in_indexed), .in_dbl(in_dbl),
    .in_ro(in_ro), .in_copy(in_copy), .in_index(in_index), .out_valid(out_valid),
    .out_base(out_base), .out_len(out_len), .out_present(out_present),
    .out_indexed(out_indexed), .out_dbl(out_dbl), .out_ro(out_ro), .out_copy(out_copy),
    .out_abs(out_abs), .irq_absent(irq_absent), .irq_badop(irq_badop),
    .irq_range(irq_range), .irq_rdonly(irq_rdonly)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cycles);
      finish_run();
    end
  end

  // reference model written from the requirements
  function automatic logic [EW-1:0] model(input logic [1:0] op, input logic [AW-1:0] b,
      input logic [LW-1:0] l, input logic p, input logic i, input logic d, input logic r,
      input logic c, input logic [LW-1:0] x);
    logic [LW:0] sc;
    logic fa, fb, fr, fw;
    logic [LW-1:0] nl;
    logic ni;
    logic [AW-1:0] ab;
    sc = d ? ({1'b0, x} * 2) : {1'b0, x};
    fa = 0; fb = 0; fr = 0; fw = 0; nl = l; ni = i; ab = '0;
    if (!p) fa = 1;
    else if (op == 2'b11 || (op == 2'b00 && i) || (op != 2'b00 && !i)) fb = 1;
    else if (op == 2'b00 && sc >= {1'b0, l}) fr = 1;
    else if (op == 2'b10 && r) fw = 1;
    else if (op == 2'b00) begin nl = sc[LW-1:0]; ni = 1; end
    else ab = AW'(b + l);
    return {b, nl, p, ni, d, r, c, ab, fa, fb, fr, fw};
  endfunction

  task automatic send(input string tag, input logic [1:0] op, input logic [AW-1:0] b,
      input logic [LW-1:0] l, input logic p, input logic i, input logic d, input logic r,
      input logic c, input logic [LW-1:0] x);
    @(negedge clk);
    in_valid = 1; in_op = op; in_base = b; in_len = l; in_present = p;
    in_indexed = i; in_dbl = d; in_ro = r; in_copy = c; in_index = x;
    exp_q.push_back(model(op, b, l, p, i, d, r, c, x));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [EW-1:0] act;
      act = {out_base, out_len, out_present, out_indexed, out_dbl, out_ro, out_copy,
             out_abs, irq_absent, irq_badop, irq_range, irq_rdonly};
      checks = checks + 1;
      if (exp_q.size() == 0) begin
        fails = fails + 1;
        $display("FAIL R2: result with no request, actual %h expected none", act);
      end else begin
        logic [EW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          fails = fails + 1;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks = checks + 1;
    if (out_valid !== 0 || {irq_absent, irq_badop, irq_range, irq_rdonly} !== 0) begin
      fails = fails + 1;
      $display("FAIL R1: actual %b%b%b%b%b expected 00000", out_valid, irq_absent,
               irq_badop, irq_range, irq_rdonly);
    end
    rst = 0;
    @(negedge clk);
    checks = checks + 1;
    if (out_valid !== 0) begin
      fails = fails + 1;
      $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
    end
    // R4: in-range index, low boundary and high boundary (R6 accept edge)
    send("R4", 2'b00, 20'h12340, 20'd10, 1, 0, 0, 0, 1, 20'd3);
    send("R4", 2'b00, 20'h00100, 20'd10, 1, 0, 0, 1, 0, 20'd0);
    send("R6", 2'b00, 20'h00100, 20'd10, 1, 0, 0, 0, 0, 20'd9);
    send("R6", 2'b00, 20'h00100, 20'd10, 1, 0, 0, 0, 0, 20'd10);
    idle();
    // R2: the idle gap above must give no result
    @(negedge clk);
    checks = checks + 1;
    if (out_valid !== 0) begin
      fails = fails + 1;
      $display("FAIL R2: idle gap actual out_valid %b expected 0", out_valid);
    end
    // R5: doubling
    send("R5", 2'b00, 20'h00200, 20'd7, 1, 0, 1, 0, 0, 20'd3);
    send("R5", 2'b00, 20'h00200, 20'd8, 1, 0, 1, 0, 0, 20'd4);
    send("R5", 2'b00, 20'h00200, 20'hFFFFF, 1, 0, 1, 0, 0, 20'h80001);
    // R7: already indexed
    send("R7", 2'b00, 20'h00300, 20'd5, 1, 1, 0, 0, 0, 20'd1);
    // R3 and R11: absent descriptor breaking several rules at once
    send("R3", 2'b00, 20'h00400, 20'd5, 0, 0, 0, 0, 0, 20'd9);
    send("R11", 2'b10, 20'h00400, 20'd5, 0, 1, 0, 1, 1, 20'd0);
    send("R11", 2'b11, 20'h00400, 20'd5, 1, 1, 0, 1, 0, 20'd0);
    send("R11", 2'b00, 20'h00400, 20'd5, 1, 1, 0, 0, 0, 20'd7);
    // R8: access through indexed descriptors, including wrap
    send("R8", 2'b01, 20'h01000, 20'd25, 1, 1, 0, 0, 0, 20'd0);
    send("R8", 2'b10, 20'hFFFFF, 20'd2, 1, 1, 1, 0, 1, 20'd0);
    // R9: read-only
    send("R9", 2'b10, 20'h02000, 20'd4, 1, 1, 0, 1, 0, 20'd0);
    send("R9", 2'b01, 20'h02000, 20'd4, 1, 1, 0, 1, 0, 20'd0);
    // R10: non-indexed access and illegal op
    send("R10", 2'b01, 20'h03000, 20'd4, 1, 0, 0, 0, 0, 20'd0);
    send("R10", 2'b11, 20'h03000, 20'd4, 1, 0, 0, 0, 0, 20'd0);
    send("R3", 2'b01, 20'h03000, 20'd4, 0, 1, 0, 0, 0, 20'd0);
    idle();
    repeat (4) @(negedge clk);
    checks = checks + 1;
    if (exp_q.size() != 0) begin
      fails = fails + 1;
      $display("FAIL R2: results missing, actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule